// File: doc/BRIEF.md
# Per-Processor Interrupt Pending Bank

This block keeps a 32-bit pending word for each processor in a multiprocessor system, up to sixteen of them. Every pending word mixes two kinds of request. Hardware sources raise or drop a single bit whose index is their priority level, in bits 15 to 1. Software raises soft requests in bits 31 to 17. From each word the block derives a 4-bit request level, and it presents that level to its processor together with a request flag and a wake indication.

Software reaches the bank through a register request channel with valid/ready handshakes. Address bits 15:12 pick the processor's 4 KiB page. Address bits 3:2 pick the word inside the page: word 0 reads the pending bits, word 1 clears soft bits and word 2 sets soft bits. A read produces one entry on a response channel that is also valid/ready. The request channel applies back-pressure: `req_ready` stays low while a response is held and not yet taken. Writes produce no response. The hardware event port is a plain strobe that carries a processor index, a level and an on/off flag. All processors are evaluated in parallel on every clock.

Top module: `pcpu_pend_bank`

## Requirements
- R1: While reset is held, and after it is released, every pending word is zero. `irq_lvl`, `irq_req`, `wake` and `rsp_valid` are all zero.
- R2: A request addresses processor `req_addr[15:12]` and word `req_addr[3:2]`. All other address bits are ignored.
- R3: An accepted read of word 0 returns that processor's pending word as it stood before the accepting edge. An accepted read of words 1, 2 or 3 returns zero.
- R4: An accepted write to word 2 ORs `req_wdata & 0xFFFE0000` into the pending word. Bits 16 to 0 can never be set this way.
- R5: An accepted write to word 1 clears the bits of `req_wdata & 0xFFFE0000`. Hardware bits 15 to 1 are left untouched.
- R6: Writes to word 0 and to word 3 change no pending bit.
- R7: When `src_valid` is high with `src_lvl` = L in 1..15, bit L of processor `src_cpu` is set if `src_on` is 1 and cleared if it is 0. Other processors are not affected. An event with L = 0 is ignored.
- R8: The level `irq_lvl[4i+3:4i]` is the larger of two values: the highest set hardware bit index in 15..1, and the highest set soft bit index in 31..17 minus 16. It is zero when neither field has a bit set. It follows the pending word in the cycle after the updating edge.
- R9: `wake[i]` is high whenever the level of processor i is nonzero. `irq_req[i]` is high only when the level is nonzero and `in_service[i]` is low.
- R10: A request is accepted on `req_valid & req_ready`. A read raises `rsp_valid` in the next cycle. `rsp_data` then holds steady until `rsp_ready`. `req_ready` equals `!rsp_valid | rsp_ready`.
- R11: A bus write and a hardware event that reach the same processor in one cycle both take effect. A read in that cycle returns the value from before both of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address (page = processor, bits 3:2 = word) |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 32 | Read response data |
| src_valid | input | 1 | Hardware level event strobe |
| src_cpu | input | 4 | Target processor of the event |
| src_lvl | input | 4 | Level of the event (0 ignored) |
| src_on | input | 1 | 1 = raise, 0 = drop |
| in_service | input | 16 | Processor i is servicing an interrupt |
| irq_req | output | 16 | Deliverable request per processor |
| irq_lvl | output | 64 | 4-bit level per processor, processor i at [4i+3:4i] |
| wake | output | 16 | Pending request per processor, wakes a halted core |

## Verification
The interesting overlap is a software register access and a hardware level event that land on the same processor's word in the same clock. The bench drives a soft-bit set write and a hardware event to one processor in a single cycle. It then reads back the combined word and the resulting level. In a second case it issues a read together with an event and expects the pre-event value in the response. A behavioural model updates its own per-processor words in the same order every cycle, and all outputs are compared against it on each clock.

// File: rtl/pcpu_pend_pkg.sv
package pcpu_pend_pkg;

  // Word selected by address bits 3:2 inside a processor page.
  typedef enum logic [1:0] {
    WORD_PEND = 2'd0,
    WORD_CLR  = 2'd1,
    WORD_SET  = 2'd2,
    WORD_NONE = 2'd3
  } pend_word_e;

endpackage

// File: rtl/pcpu_addr_dec.sv
module pcpu_addr_dec
  import pcpu_pend_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int PAGE_LSB = 12,
  parameter int CPU_W    = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [CPU_W-1:0]  cpu_idx,
  output pend_word_e        word
);
  logic unused_addr_bits;

  assign cpu_idx = addr[PAGE_LSB+CPU_W-1:PAGE_LSB];
  assign word    = pend_word_e'(addr[3:2]);
  assign unused_addr_bits = ^{addr[ADDR_W-1:PAGE_LSB+CPU_W], addr[PAGE_LSB-1:4], addr[1:0]};
endmodule

// File: rtl/pcpu_pend_slot.sv
module pcpu_pend_slot #(
  parameter int LVL_W = 4,
  localparam int REG_W = 2 ** (LVL_W + 1),
  localparam int HALF  = 2 ** LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_en,
  input  logic             set_en,
  input  logic [REG_W-1:0] wdata,
  input  logic             src_hit,
  input  logic [LVL_W-1:0] src_lvl,
  input  logic             src_on,
  input  logic             in_service,
  output logic [REG_W-1:0] pend_o,
  output logic [LVL_W-1:0] lvl_o,
  output logic             req_o,
  output logic             wake_o
);
  // Soft bits are those above the midpoint bit.
  localparam logic [REG_W-1:0] SOFT_MASK = ~((REG_W'(1) << (HALF + 1)) - REG_W'(1));

  logic [REG_W-1:0] pend_q, pend_d;
  logic [LVL_W-1:0] hw_top, soft_top;

  always_comb begin
    pend_d = pend_q;
    if (clr_en) pend_d = pend_d & ~(wdata & SOFT_MASK);
    if (set_en) pend_d = pend_d | (wdata & SOFT_MASK);
    if (src_hit && (src_lvl != '0)) pend_d[src_lvl] = src_on;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // Highest hardware level present in bits HALF-1..1.
  always_comb begin
    hw_top = '0;
    for (int j = 1; j < HALF; j++)
      if (pend_q[j]) hw_top = LVL_W'(j);
  end

  // Highest soft bit, rebased so bit HALF+1 is level 1.
  always_comb begin
    soft_top = '0;
    for (int j = HALF + 1; j < REG_W; j++)
      if (pend_q[j]) soft_top = LVL_W'(j - HALF);
  end

  assign lvl_o  = (soft_top > hw_top) ? soft_top : hw_top;
  assign wake_o = (lvl_o != '0);
  assign req_o  = wake_o & ~in_service;
  assign pend_o = pend_q;
endmodule

// File: rtl/pcpu_rsp_port.sv
module pcpu_rsp_port
  import pcpu_pend_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  pend_word_e        word,
  input  logic [DATA_W-1:0] sel_pend,
  output logic              req_ready,
  output logic              accept,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data
);
  logic rd_fire;

  assign req_ready = ~rsp_valid | rsp_ready;
  assign accept    = req_valid & req_ready;
  assign rd_fire   = accept & ~req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= (word == WORD_PEND) ? sel_pend : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pcpu_pend_bank.sv
module pcpu_pend_bank
  import pcpu_pend_pkg::*;
#(
  parameter int NUM_CPU  = 16,
  parameter int LVL_W    = 4,
  parameter int ADDR_W   = 16,
  parameter int PAGE_LSB = 12,
  localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int REG_W   = 2 ** (LVL_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [REG_W-1:0]         req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [REG_W-1:0]         rsp_data,
  input  logic                     src_valid,
  input  logic [CPU_W-1:0]         src_cpu,
  input  logic [LVL_W-1:0]         src_lvl,
  input  logic                     src_on,
  input  logic [NUM_CPU-1:0]       in_service,
  output logic [NUM_CPU-1:0]       irq_req,
  output logic [NUM_CPU*LVL_W-1:0] irq_lvl,
  output logic [NUM_CPU-1:0]       wake
);
  logic [CPU_W-1:0]         dec_cpu;
  pend_word_e               dec_word;
  logic                     accept, wr_fire;
  logic [REG_W-1:0]         pend_arr [NUM_CPU];
  logic [NUM_CPU*REG_W-1:0] pend_flat;
  logic [REG_W-1:0]         sel_pend;

  pcpu_addr_dec #(
    .ADDR_W  (ADDR_W),
    .PAGE_LSB(PAGE_LSB),
    .CPU_W   (CPU_W)
  ) dec_i (
    .addr   (req_addr),
    .cpu_idx(dec_cpu),
    .word   (dec_word)
  );

  assign wr_fire = accept & req_write;

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    logic hit_bus, hit_src;
    assign hit_bus = wr_fire && (dec_cpu == CPU_W'(g));
    assign hit_src = src_valid && (src_cpu == CPU_W'(g));

    pcpu_pend_slot #(.LVL_W(LVL_W)) slot_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_en    (hit_bus && (dec_word == WORD_CLR)),
      .set_en    (hit_bus && (dec_word == WORD_SET)),
      .wdata     (req_wdata),
      .src_hit   (hit_src),
      .src_lvl   (src_lvl),
      .src_on    (src_on),
      .in_service(in_service[g]),
      .pend_o    (pend_arr[g]),
      .lvl_o     (irq_lvl[g*LVL_W +: LVL_W]),
      .req_o     (irq_req[g]),
      .wake_o    (wake[g])
    );

    assign pend_flat[g*REG_W +: REG_W] = pend_arr[g];
  end

  assign sel_pend = pend_arr[dec_cpu];

  pcpu_rsp_port #(.DATA_W(REG_W)) rsp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .word     (dec_word),
    .sel_pend (sel_pend),
    .req_ready(req_ready),
    .accept   (accept),
    .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready),
    .rsp_data (rsp_data)
  );
endmodule

// File: rtl/pcpu_pend_bank_chk.sv
module pcpu_pend_bank_chk #(
  parameter int NUM_CPU = 16,
  parameter int REG_W   = 32,
  parameter int ADDR_W  = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     req_valid,
  input logic                     req_ready,
  input logic                     req_write,
  input logic [ADDR_W-1:0]        req_addr,
  input logic                     src_valid,
  input logic                     rsp_valid,
  input logic                     rsp_ready,
  input logic [REG_W-1:0]         rsp_data,
  input logic [NUM_CPU-1:0]       in_service,
  input logic [NUM_CPU-1:0]       irq_req,
  input logic [NUM_CPU-1:0]       wake,
  input logic [NUM_CPU*REG_W-1:0] pend_flat
);
  localparam int MID = REG_W / 2;

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pend_flat == '0) && !rsp_valid);

  assert_svc_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & in_service) == '0);

  assert_req_implies_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req & ~wake) == '0);

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  assert_stall_backpressure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  assert_word3_noop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_write && (req_addr[3:2] == 2'd3) && !src_valid
    |=> $stable(pend_flat));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_rsvd
    assert_rsvd_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_flat[c*REG_W] && !pend_flat[c*REG_W + MID]);
  end
endmodule

bind pcpu_pend_bank pcpu_pend_bank_chk #(
  .NUM_CPU(NUM_CPU),
  .REG_W  (REG_W),
  .ADDR_W (ADDR_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .src_valid (src_valid),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .in_service(in_service),
  .irq_req   (irq_req),
  .wake      (wake),
  .pend_flat (pend_flat)
);

// File: tb/pcpu_pend_bank_tb_top.sv
module pcpu_pend_bank_tb_top;
  localparam int N  = 16;
  localparam int LW = 4;
  localparam int RW = 32;
  localparam int AW = 16;
  localparam logic [31:0] SMASK = 32'hFFFE_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [AW-1:0] req_addr = '0;
  logic [RW-1:0] req_wdata = '0;
  logic          src_valid = 0, src_on = 0;
  logic [3:0]    src_cpu = '0;
  logic [LW-1:0] src_lvl = '0;
  logic [N-1:0]  in_service = '0;
  logic          req_ready, rsp_valid;
  logic [RW-1:0] rsp_data;
  logic [N-1:0]  irq_req, wake;
  logic [N*LW-1:0] irq_lvl;

  pcpu_pend_bank dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .src_valid(src_valid), .src_cpu(src_cpu), .src_lvl(src_lvl), .src_on(src_on),
    .in_service(in_service), .irq_req(irq_req), .irq_lvl(irq_lvl), .wake(wake)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [RW-1:0] last_rsp;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [RW-1:0] m_pend [N];
  logic          m_rv;
  logic [RW-1:0] m_rd;

  function automatic logic [LW-1:0] m_level(input logic [RW-1:0] p);
    int best;
    best = 0;
    for (int i = 1; i < 16; i++) if (p[i]) best = i;
    for (int i = 17; i < 32; i++) if (p[i] && (i - 16) > best) best = i - 16;
    return LW'(best);
  endfunction

  always @(posedge clk) begin
    bit acc;
    int c;
    int w;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_pend[i] = '0;
      m_rv = 0;
      m_rd = '0;
    end else begin
      acc = req_valid && (!m_rv || rsp_ready);
      c = int'(req_addr[15:12]);
      w = int'(req_addr[3:2]);
      if (acc && !req_write) begin
        m_rv = 1;
        m_rd = (w == 0) ? m_pend[c] : '0;
      end else if (rsp_ready) begin
        m_rv = 0;
      end
      if (acc && req_write && w == 1) m_pend[c] = m_pend[c] & ~(req_wdata & SMASK);
      if (acc && req_write && w == 2) m_pend[c] = m_pend[c] | (req_wdata & SMASK);
      if (src_valid && src_lvl != 0) m_pend[src_cpu][src_lvl] = src_on;
    end
  end

  // compare on every clock, 3 ns after the edge
  always @(posedge clk) begin
    logic [N*LW-1:0] e_lvl;
    logic [N-1:0]    e_req, e_wake;
    #3;
    if (rst_n && !done) begin
      for (int i = 0; i < N; i++) begin
        e_lvl[i*LW +: LW] = m_level(m_pend[i]);
        e_wake[i] = (m_level(m_pend[i]) != 0);
        e_req[i]  = e_wake[i] && !in_service[i];
      end
      chk("R8 level vector", 64'(irq_lvl), 64'(e_lvl));
      chk("R9 irq_req", 64'(irq_req), 64'(e_req));
      chk("R9 wake", 64'(wake), 64'(e_wake));
      chk("R10 req_ready", 64'(req_ready), 64'(!m_rv || rsp_ready));
      chk("R10 rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) chk("R3 rsp_data", 64'(rsp_data), 64'(m_rd));
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [AW-1:0] adr(input int cpu, input int word);
    return {4'(cpu), 8'h00, 2'(word), 2'b00};
  endfunction

  task automatic op(input bit rq, input bit wr, input logic [AW-1:0] a, input logic [RW-1:0] d,
                    input bit sv, input int sc, input int sl, input bit so);
    @(negedge clk);
    req_valid = rq; req_write = wr; req_addr = a; req_wdata = d;
    src_valid = sv; src_cpu = 4'(sc); src_lvl = LW'(sl); src_on = so;
    @(posedge clk);
    #3;
    if (rsp_valid) last_rsp = rsp_data;
    @(negedge clk);
    req_valid = 0; src_valid = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    op(1, 0, a, '0, 0, 0, 0, 0);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [RW-1:0] d);
    op(1, 1, a, d, 0, 0, 0, 0);
  endtask

  task automatic src(input int cpu, input int lvl, input bit on);
    op(0, 0, '0, '0, 1, cpu, lvl, on);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [RW-1:0] held;
    repeat (3) @(posedge clk);
    #3;
    chk("R1 rsp_valid in reset", 64'(rsp_valid), 64'd0);
    chk("R1 irq_lvl in reset", 64'(irq_lvl), 64'd0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #3;
    chk("R1 irq_req after reset", 64'(irq_req), 64'd0);
    chk("R1 wake after reset", 64'(wake), 64'd0);
    rd(adr(7, 0));
    chk("R1 pending after reset", 64'(last_rsp), 64'd0);

    // R4 set soft bits, low half masked
    wr(adr(3, 2), 32'h8002_FFFF);
    rd(adr(3, 0));
    chk("R4 set masked", 64'(last_rsp), 64'h8002_0000);
    chk("R8 top soft level", 64'(irq_lvl[3*LW +: LW]), 64'd15);

    // R5 clear
    wr(adr(3, 1), 32'h8000_0000);
    rd(adr(3, 0));
    chk("R5 clear bit31", 64'(last_rsp), 64'h0002_0000);
    chk("R8 level 1 from bit17", 64'(irq_lvl[3*LW +: LW]), 64'd1);

    // R7 hardware level
    src(3, 5, 1);
    rd(adr(3, 0));
    chk("R7 hw raise", 64'(last_rsp), 64'h0002_0020);
    chk("R8 hw over soft", 64'(irq_lvl[3*LW +: LW]), 64'd5);
    rd(adr(4, 0));
    chk("R7 other cpu untouched", 64'(last_rsp), 64'd0);
    wr(adr(3, 1), 32'hFFFF_FFFF);
    rd(adr(3, 0));
    chk("R5 hw bits survive clear", 64'(last_rsp), 64'h0000_0020);

    // R7 level 0 ignored
    src(3, 0, 1);
    rd(adr(3, 0));
    chk("R7 level0 ignored", 64'(last_rsp), 64'h0000_0020);

    // R6 dead words, R3 reads of other words
    wr(adr(3, 0), 32'hFFFF_FFFF);
    wr(adr(3, 3), 32'hFFFF_FFFF);
    rd(adr(3, 0));
    chk("R6 word0/3 writes ignored", 64'(last_rsp), 64'h0000_0020);
    rd(adr(3, 1));
    chk("R3 word1 reads zero", 64'(last_rsp), 64'd0);

    // R2 ignored address bits
    rd(16'h3FF0);
    chk("R2 stray address bits", 64'(last_rsp), 64'h0000_0020);

    // R9 in-service blocks request, not wake
    @(negedge clk) in_service[3] = 1;
    @(posedge clk); #3;
    chk("R9 request blocked", 64'(irq_req[3]), 64'd0);
    chk("R9 wake stays", 64'(wake[3]), 64'd1);
    @(negedge clk) in_service[3] = 0;

    // R11 same-cycle bus write and hw event
    op(1, 1, adr(5, 2), 32'h0040_0000, 1, 5, 9, 1);
    rd(adr(5, 0));
    chk("R11 both applied", 64'(last_rsp), 64'h0040_0200);
    chk("R8 max of fields", 64'(irq_lvl[5*LW +: LW]), 64'd9);

    // R11 read in same cycle as event returns old value
    op(1, 0, adr(5, 0), '0, 1, 5, 2, 1);
    chk("R11 read sees old value", 64'(last_rsp), 64'h0040_0200);
    rd(adr(5, 0));
    chk("R7 event after read", 64'(last_rsp), 64'h0040_0204);
    src(5, 9, 0);
    rd(adr(5, 0));
    chk("R7 hw drop", 64'(last_rsp), 64'h0040_0004);

    // R10 back-pressure
    @(negedge clk);
    rsp_ready = 0;
    req_valid = 1; req_write = 0; req_addr = adr(5, 0);
    @(posedge clk); #3;
    chk("R10 response raised", 64'(rsp_valid), 64'd1);
    chk("R10 ready low while stalled", 64'(req_ready), 64'd0);
    held = rsp_data;
    @(negedge clk) req_valid = 0;
    repeat (2) @(posedge clk);
    #3;
    chk("R10 response held", 64'(rsp_valid), 64'd1);
    chk("R10 data stable", 64'(rsp_data), 64'(held));
    @(negedge clk) rsp_ready = 1;
    @(posedge clk); #3;
    chk("R10 response drained", 64'(rsp_valid), 64'd0);

    repeat (4) @(posedge clk);
    #4;
    finish_run();
  end
endmodule